// File: doc/BRIEF.md
# Floating-Point Compare Unit with Condition and Status Update

This unit compares two 64-bit IEEE-754 double-precision operands. It writes a one-hot 4-bit result code into one of eight 4-bit fields of a 32-bit condition register. It also returns an updated 32-bit floating-point status/control word. Each operand is classified as a number, a zero, a quiet NaN or a signalling NaN. Numbers are ordered by sign and magnitude, and positive and negative zero compare equal.

Two compare flavours are supported. The unordered flavour only raises the sticky signalling-NaN invalid flag. The ordered flavour also raises the sticky invalid-compare flag, using the rule given in R7.

Requests enter on a valid/ready channel together with the current condition register and status word. The result leaves on a second valid/ready channel after one register stage. The result stays held, with its data unchanged, until the consumer takes it. The rules for back-pressure are as follows:
- A request is accepted on a rising clock edge where both `req_valid` and `req_ready` are high.
- `req_ready` is high whenever the output stage is empty or is being emptied in the same cycle.
- Once `rsp_valid` rises, it stays high and all response data stays stable until `rsp_ready` is seen high on a rising edge.

Top module: `fcmp_unit`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. Its result appears on the response outputs with `rsp_valid` high in the following cycle. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `cr_out` and `st_out` hold their values.
- R2: If either operand has exponent 0x7FF and a nonzero fraction (a NaN), the result code is 4'b0001.
- R3: Otherwise the code is 4'b1000 when A < B, 4'b0100 when A > B, and 4'b0010 when they are equal. Ordering is sign-magnitude, and +0 equals -0.
- R4: `cr_out` equals `cr_in` except for field `fld_sel`. Field k occupies bits [31-4k:28-4k], so field 0 is the most significant nibble. The selected field receives the code, which has exactly one bit set.
- R5: `st_out[15:12]` equals the code. All other bits of `st_out` equal `st_in`, except for the two flags set under R6 and R7.
- R6: If either operand is a signalling NaN (fraction MSB, bit 51, is zero), `st_out[24]` is set. This applies in both modes.
- R7: In ordered mode (`ordered`=1) with no signalling NaN, `st_out[19]` is set when the enable bit `st_in[7]` is clear or when either operand is a quiet NaN (bit 51 is one). In unordered mode, bit 19 passes through unchanged.
- R8: Bits 24 and 19 are sticky. Once they are set in `st_in`, they are never cleared in `st_out`.
- R9: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| op_a | input | 64 | First operand (IEEE double bits) |
| op_b | input | 64 | Second operand (IEEE double bits) |
| ordered | input | 1 | 1 = ordered compare, 0 = unordered compare |
| fld_sel | input | 3 | Destination condition field, 0 = most significant nibble |
| cr_in | input | 32 | Current condition register |
| st_in | input | 32 | Current status/control word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| cr_out | output | 32 | Updated condition register |
| st_out | output | 32 | Updated status/control word |

## Verification
Random operand pairs are drawn from a mix of classes: normal and subnormal numbers, signed zeros, infinities, quiet NaNs, signalling NaNs and bit-identical copies. Each class separates a different branch of the code choice:
- Copies and signed zeros separate equality from the sign and magnitude paths.
- Opposite signs check the sign shortcut.
- The two NaN kinds separate the unordered code from the two sticky-flag rules.

Random status words, with the enable bit both set and clear and the sticky bits preset, test flag pass-through and stickiness. A walk over all eight field selects checks the nibble placement. A stall with `rsp_ready` held low checks that the result is held and that new requests are refused.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int DW     = EXP_W + FRAC_W + 1;
  localparam int NIB    = 4;
  localparam int NFLD   = 8;
  localparam int CRW    = NIB * NFLD;
  localparam int SELW   = $clog2(NFLD);

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } order_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int DW    = EXP_W + FRAC_W + 1
) (
  input  logic [DW-1:0] val,
  output logic          sign,
  output logic [DW-2:0] mag,
  output logic          is_zero,
  output logic          is_qnan,
  output logic          is_snan
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_max;
  logic              frac_nz;

  always_comb begin
    sign    = val[DW-1];
    mag     = val[DW-2:0];
    expo    = val[DW-2 -: EXP_W];
    frac    = val[FRAC_W-1:0];
    exp_max = &expo;
    frac_nz = |frac;
    is_zero = (mag == '0);
    is_qnan = exp_max && frac[FRAC_W-1];
    is_snan = exp_max && frac_nz && !frac[FRAC_W-1];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int MW = 63
) (
  input  logic          sa,
  input  logic [MW-1:0] ma,
  input  logic          za,
  input  logic          sb,
  input  logic [MW-1:0] mb,
  input  logic          zb,
  output fcmp_pkg::order_t ord
);
  logic mag_lt;
  logic mag_eq;

  always_comb begin
    mag_lt = (ma < mb);
    mag_eq = (ma == mb);
    ord    = '0;
    if (za && zb) begin
      ord.eq = 1'b1;
    end else if (sa != sb) begin
      ord.lt = sa;
      ord.gt = sb;
    end else if (mag_eq) begin
      ord.eq = 1'b1;
    end else if (sa) begin
      ord.lt = !mag_lt;
      ord.gt = mag_lt;
    end else begin
      ord.lt = mag_lt;
      ord.gt = !mag_lt;
    end
  end
endmodule

// File: rtl/fcmp_merge.sv
module fcmp_merge #(
  parameter int NIB      = 4,
  parameter int NFLD     = 8,
  parameter int STW      = 32,
  parameter int CC_LSB   = 12,
  parameter int SNAN_BIT = 24,
  parameter int VC_BIT   = 19,
  parameter int VE_BIT   = 7,
  localparam int CRW     = NIB * NFLD,
  localparam int SELW    = $clog2(NFLD)
) (
  input  fcmp_pkg::order_t ord,
  input  logic             nan_any,
  input  logic             snan_any,
  input  logic             qnan_any,
  input  logic             ordered,
  input  logic [SELW-1:0]  fld_sel,
  input  logic [CRW-1:0]   cr_in,
  input  logic [STW-1:0]   st_in,
  output logic [CRW-1:0]   cr_nx,
  output logic [STW-1:0]   st_nx
);
  logic [NIB-1:0] code;

  always_comb begin
    if (nan_any) code = 4'b0001;
    else         code = {ord.lt, ord.gt, ord.eq, 1'b0};
  end

  for (genvar k = 0; k < NFLD; k++) begin : g_fld
    assign cr_nx[CRW-1-NIB*k -: NIB] =
      (fld_sel == SELW'(k)) ? code : cr_in[CRW-1-NIB*k -: NIB];
  end

  always_comb begin
    st_nx = st_in;
    st_nx[CC_LSB +: NIB] = code;
    if (snan_any)
      st_nx[SNAN_BIT] = 1'b1;
    else if (ordered && (!st_in[VE_BIT] || qnan_any))
      st_nx[VC_BIT] = 1'b1;
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int STW      = 32,
  parameter int CC_LSB   = 12,
  parameter int SNAN_BIT = 24,
  parameter int VC_BIT   = 19,
  parameter int VE_BIT   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  input  logic            ordered,
  input  logic [SELW-1:0] fld_sel,
  input  logic [CRW-1:0]  cr_in,
  input  logic [STW-1:0]  st_in,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [CRW-1:0]  cr_out,
  output logic [STW-1:0]  st_out
);
  logic [DW-1:0] opv   [2];
  logic          sgn   [2];
  logic [DW-2:0] mag   [2];
  logic          zro   [2];
  logic          qn    [2];
  logic          sn    [2];

  assign opv[0] = op_a;
  assign opv[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val(opv[i]), .sign(sgn[i]), .mag(mag[i]),
      .is_zero(zro[i]), .is_qnan(qn[i]), .is_snan(sn[i])
    );
  end

  order_t ord;
  fcmp_order #(.MW(DW-1)) u_ord (
    .sa(sgn[0]), .ma(mag[0]), .za(zro[0]),
    .sb(sgn[1]), .mb(mag[1]), .zb(zro[1]),
    .ord(ord)
  );

  logic snan_any, qnan_any, nan_any;
  assign snan_any = sn[0] | sn[1];
  assign qnan_any = qn[0] | qn[1];
  assign nan_any  = snan_any | qnan_any;

  logic [CRW-1:0] cr_nx;
  logic [STW-1:0] st_nx;
  fcmp_merge #(
    .NIB(NIB), .NFLD(NFLD), .STW(STW), .CC_LSB(CC_LSB),
    .SNAN_BIT(SNAN_BIT), .VC_BIT(VC_BIT), .VE_BIT(VE_BIT)
  ) u_mrg (
    .ord(ord), .nan_any(nan_any), .snan_any(snan_any), .qnan_any(qnan_any),
    .ordered(ordered), .fld_sel(fld_sel), .cr_in(cr_in), .st_in(st_in),
    .cr_nx(cr_nx), .st_nx(st_nx)
  );

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      cr_out    <= '0;
      st_out    <= '0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        cr_out    <= cr_nx;
        st_out    <= st_nx;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk #(
  parameter int STW      = 32,
  parameter int CRW      = 32,
  parameter int CC_LSB   = 12,
  parameter int SNAN_BIT = 24,
  parameter int VC_BIT   = 19
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           ordered,
  input logic [STW-1:0] st_in,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [CRW-1:0] cr_out,
  input logic [STW-1:0] st_out
);
  // R1
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(cr_out) && $stable(st_out)));

  // R4
  code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(st_out[CC_LSB +: 4]) == 1);

  // R8
  snan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && st_in[SNAN_BIT]) |=> st_out[SNAN_BIT]);

  // R8
  vc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && st_in[VC_BIT]) |=> st_out[VC_BIT]);

  // R7
  unord_vc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ordered) |=> st_out[VC_BIT] == $past(st_in[VC_BIT]));
endmodule

bind fcmp_unit fcmp_chk #(
  .STW(STW), .CRW(fcmp_pkg::CRW), .CC_LSB(CC_LSB),
  .SNAN_BIT(SNAN_BIT), .VC_BIT(VC_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ordered(ordered), .st_in(st_in), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .cr_out(cr_out), .st_out(st_out)
);

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] op_a = '0, op_b = '0;
  logic        ordered = 1'b0;
  logic [2:0]  fld_sel = '0;
  logic [31:0] cr_in = '0, st_in = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] cr_out, st_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  fcmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op_a(op_a), .op_b(op_b), .ordered(ordered), .fld_sel(fld_sel),
    .cr_in(cr_in), .st_in(st_in), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .cr_out(cr_out), .st_out(st_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic bit is_nan(logic [63:0] v);
    return v[62:52] == 11'h7FF && v[51:0] != 0;
  endfunction
  function automatic bit is_sn(logic [63:0] v);
    return is_nan(v) && !v[51];
  endfunction
  function automatic bit is_qn(logic [63:0] v);
    return is_nan(v) && v[51];
  endfunction

  // expected {cr, st} from R2..R8
  function automatic logic [63:0] ref_out(logic [63:0] a, logic [63:0] b, bit ord,
                                          logic [2:0] sel, logic [31:0] cr, logic [31:0] st);
    logic [3:0]  c;
    logic [31:0] rc, rs;
    real ra, rb;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (is_nan(a) || is_nan(b)) c = 4'b0001;
    else if (ra < rb)           c = 4'b1000;
    else if (ra > rb)           c = 4'b0100;
    else                        c = 4'b0010;
    rc = cr;
    rc[31 - 4*sel -: 4] = c;
    rs = st;
    rs[15:12] = c;
    if (is_sn(a) || is_sn(b)) rs[24] = 1'b1;
    else if (ord && (!st[7] || is_qn(a) || is_qn(b))) rs[19] = 1'b1;
    return {rc, rs};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got cr=%h st=%h expected cr=%h st=%h",
               tag, got[63:32], got[31:0], exp[63:32], exp[31:0]);
    end
  endtask

  task automatic run_vec(string tag, logic [63:0] a, logic [63:0] b, bit ord,
                         logic [2:0] sel, logic [31:0] cr, logic [31:0] st);
    @(negedge clk);
    op_a = a; op_b = b; ordered = ord; fld_sel = sel; cr_in = cr; st_in = st;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      checks++; fails++;
      $display("FAIL R1 %s: got rsp_valid=0 expected 1", tag);
    end
    check(tag, {cr_out, st_out}, ref_out(a, b, ord, sel, cr, st));
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] v;
    int k;
    v = {$urandom, $urandom};
    k = $urandom_range(0, 9);
    case (k)
      0: v[62:0] = '0;                                   // signed zero
      1: begin v[62:52] = 11'h7FF; v[51:0] = '0; end     // infinity
      2: begin v[62:52] = 11'h7FF; v[51] = 1'b1; end     // quiet NaN
      3: begin v[62:52] = 11'h7FF; v[51] = 1'b0; v[0] = 1'b1; end // signalling NaN
      4: v[62:52] = '0;                                  // subnormal
      default: if (v[62:52] == 11'h7FF) v[62] = 1'b0;     // normal
    endcase
    return v;
  endfunction

  localparam logic [63:0] P0   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N0   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P1   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N1   = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P2   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] N2   = 64'hC000_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R9: got rsp_valid=%b req_ready=%b expected 0 1", rsp_valid, req_ready);
    end
    rst_n = 1'b1;

    // R3 directed ordering
    run_vec("R3 +0 vs -0",   P0, N0, 1'b0, 3'd0, 32'h0, 32'h0);
    run_vec("R3 -1 vs +1",   N1, P1, 1'b0, 3'd1, 32'hFFFF_FFFF, 32'h0);
    run_vec("R3 -1 vs -2",   N1, N2, 1'b0, 3'd2, 32'h1234_5678, 32'h0);
    run_vec("R3 +1 vs +2",   P1, P2, 1'b0, 3'd3, 32'h0, 32'h0);
    run_vec("R3 inf vs inf", PINF, PINF, 1'b0, 3'd4, 32'h0, 32'h0);
    run_vec("R3 -0 vs -1",   N0, N1, 1'b0, 3'd5, 32'h0, 32'h0);
    // R2 / R7 / R6
    run_vec("R2 R7 qnan unordered", QNAN, P1, 1'b0, 3'd0, 32'h0, 32'h0000_0080);
    run_vec("R7 qnan ordered ve=1", P1, QNAN, 1'b1, 3'd0, 32'h0, 32'h0000_0080);
    run_vec("R7 num ordered ve=0",  P1, P2, 1'b1, 3'd0, 32'h0, 32'h0);
    run_vec("R7 num ordered ve=1",  P1, P2, 1'b1, 3'd0, 32'h0, 32'h0000_0080);
    run_vec("R6 snan unordered",    SNAN, P1, 1'b0, 3'd7, 32'h0, 32'h0);
    run_vec("R6 snan ordered",      P1, SNAN, 1'b1, 3'd7, 32'h0, 32'h0000_0000);
    // R8 sticky and R5 pass-through
    run_vec("R8 sticky preset",     P1, P1, 1'b0, 3'd6, 32'h0, 32'h0108_F0FF);
    run_vec("R5 keep other bits",   N2, P2, 1'b1, 3'd6, 32'hA5A5_A5A5, 32'hFEF7_FFFF);
    // R4 every field
    for (int k = 0; k < 8; k++)
      run_vec("R4 field walk", N1, P1, 1'b0, 3'(k), 32'h5555_5555, 32'h0);

    // R1 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    op_a = P2; op_b = P1; ordered = 1'b0; fld_sel = 3'd0; cr_in = 32'h0; st_in = 32'h0;
    req_valid = 1'b1;
    @(negedge clk);
    op_a = N2; fld_sel = 3'd3;
    for (int s = 0; s < 3; s++) begin
      checks++;
      if (req_ready !== 1'b0 || rsp_valid !== 1'b1 || cr_out !== 32'h4000_0000
          || st_out !== 32'h0000_4000) begin
        fails++;
        $display("FAIL R1 stall: got rdy=%b vld=%b cr=%h st=%h expected 0 1 40000000 00004000",
                 req_ready, rsp_valid, cr_out, st_out);
      end
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 after stall", {cr_out, st_out}, ref_out(N2, P1, 1'b0, 3'd3, 32'h0, 32'h0));
    @(negedge clk);

    // random mix, R2 R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      a = rnd_op();
      b = ($urandom_range(0, 5) == 0) ? a : rnd_op();
      if ($urandom_range(0, 7) == 0) b = {~a[63], a[62:0]};
      run_vec("R2-R8 random", a, b, 1'($urandom), 3'($urandom), $urandom, $urandom);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule